// File: doc/BRIEF.md
# Floating-Point Register Bank Executor

This block carries out one floating-point instruction word against a bank of sixteen 64-bit registers. Each register is kept as two 32-bit halves. A single-precision value occupies only the low half. A double-precision value puts bits 31:0 in the low half and bits 63:32 in the high half. The surrounding core has already fetched the word and resolved its condition. The block presents the word together with the value of the core register it may need, the current core status word, and any precomputed results.

The block performs the following operations itself:
- register copies, absolute value and negation;
- a two-half XOR;
- expansion of an 8-bit immediate constant;
- transfers between the bank and the core registers;
- encoding of a compare outcome into a 4-bit flag set;
- merging those flags into the core status word.

Results of add, subtract, multiply, divide, square root and the conversions come in already computed on `arith_result`, and the block only writes them back. A word whose top byte marks it as a floating-point encoding but that matches nothing raises an error. Any other unmatched word is reported as not floating-point.

A peek port gives combinational read access to any register, so the surrounding logic can observe the bank.

Top module: `fpx_exec_top`

## Requirements
- R1: After reset every register half reads zero, the stored flags are 0, and done, err_unsup, not_fp, core_we and status_we are low.
- R2: Single-precision results (copy, abs, neg, immediate, arithmetic and single conversion writeback, core-to-bank transfer) change only the low half of the target register; the high half keeps its value.
- R3: Absolute value clears bit 31 of the low half (single) or of the high half (double, low half copied). Negate toggles that same bit. Fields: destination is bits 15:12 and source is bits 3:0.
- R4: XOR (word & 0xfff00ff0 == 0xf3000110) writes, for each half separately, the XOR of the registers named by bits 19:16 and bits 3:0 into the register named by bits 15:12.
- R5: A single immediate (0xeeb00a00 under mask 0xfff00ff0) is formed from imm = {bits 19:16, bits 3:0}. The result is: bit 31 = imm[7], bit 30 = ~imm[6], bits 29:25 = imm[6], bits 24:19 = imm[5:0], the rest zero.
- R6: A double immediate (0xeeb00b00 under the same mask) clears the low half. The high half is: bit 31 = imm[7], bit 30 = ~imm[6], bits 29:22 = imm[6], bits 21:16 = imm[5:0], the rest zero.
- R7: A compare (0xeeb40bc0, 0xeeb40ac0, 0xeeb50bc0 or 0xeeb50ac0 under mask 0xffff0ff0) stores flags (N,Z,C,V) as follows: unordered gives 0x3, equal gives 0x6, less gives 0x8, otherwise 0x2. Unordered wins over the other inputs. No other instruction changes the flags.
- R8: Word 0xeef1fa10 pulses status_we with status_wdata = stored flags in bits 31:28 and core_status bits 27:0.
- R9: 0xee000b10 (mask 0xfff00ff0) writes core_rdata into the low half of the register named by bits 19:16. 0xee100b10 pulses core_we with core_widx = bits 15:12 and core_wdata = low half of the register named by bits 19:16.
- R10: Arithmetic and conversion words write arith_result[31:0] to the low half (single destinations) or all of arith_result (double destinations) of the register named by bits 15:12.
- R11: An unmatched word with top byte 0xee or 0xed pulses err_unsup. Any other unmatched word pulses not_fp. Neither changes the bank, the flags or the core write ports.
- R12: The bank write and flag update happen at the clock edge that samples start. done, err_unsup or not_fp is high for exactly the following cycle, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Execute instr at this edge |
| instr | input | 32 | Instruction word |
| core_rdata | input | 32 | Core register value for core-to-bank transfer |
| core_status | input | 32 | Current core status word |
| arith_result | input | 64 | Precomputed arithmetic or conversion result |
| cmp_unord | input | 1 | Compare outcome: unordered |
| cmp_lt | input | 1 | Compare outcome: less than |
| cmp_eq | input | 1 | Compare outcome: equal |
| peek_idx | input | 4 | Register selected for observation |
| peek_data | output | 64 | {high, low} of the selected register |
| done | output | 1 | Instruction completed |
| err_unsup | output | 1 | Unsupported floating-point encoding |
| not_fp | output | 1 | Word is not a floating-point instruction |
| core_we | output | 1 | Core register write strobe |
| core_widx | output | 4 | Core register index |
| core_wdata | output | 32 | Core register data |
| status_we | output | 1 | Core status write strobe |
| status_wdata | output | 32 | New core status word |
| fp_flags | output | 4 | Stored compare flags N,Z,C,V |

## Verification
The hardest condition to reach is one where an instruction must leave state alone. Examples are a high half preserved under a single-precision write, flags preserved across non-compare words, and an erroring word that must not disturb the bank. To check these, the bench first fills every high and low half with distinct patterns through double writebacks. It then compares all sixteen registers against its own model after each group. The full 256-value immediate space is swept in both widths, each with a rotating destination, and the four compare outcomes are applied in orders that make every flag value differ from the previous one.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 4;

  typedef enum logic [4:0] {
    OP_NOTFP, OP_BAD,
    OP_MOV_S, OP_MOV_D, OP_ABS_S, OP_ABS_D, OP_NEG_S, OP_NEG_D,
    OP_XOR, OP_IMM_S, OP_IMM_D,
    OP_CORE2FP, OP_FP2CORE,
    OP_CMP, OP_FLAGCOPY,
    OP_RES_S, OP_RES_D
  } fpx_op_e;

  function automatic logic hit(input logic [31:0] w, input logic [31:0] msk,
                               input logic [31:0] val);
    return (w & msk) == val;
  endfunction

  // Instruction classification; priority follows the mask order used by the executor.
  function automatic fpx_op_e decode_word(input logic [31:0] w);
    fpx_op_e op;
    op = (w[31:24] == 8'hee || w[31:24] == 8'hed) ? OP_BAD : OP_NOTFP;
    if (w == 32'heef1fa10)                              op = OP_FLAGCOPY;
    else if (hit(w, 32'hfff00ff0, 32'hf3000110))        op = OP_XOR;
    else if (hit(w, 32'hfff00ff0, 32'heeb00b00))        op = OP_IMM_D;
    else if (hit(w, 32'hfff00ff0, 32'heeb00a00))        op = OP_IMM_S;
    else if (hit(w, 32'hfff00ff0, 32'hee300b00) || hit(w, 32'hfff00ff0, 32'hee300b40) ||
             hit(w, 32'hfff00ff0, 32'hee200b00) || hit(w, 32'hfff00ff0, 32'hee800b00))
      op = OP_RES_D;
    else if (hit(w, 32'hfff00ff0, 32'hee300a00) || hit(w, 32'hfff00ff0, 32'hee300a40) ||
             hit(w, 32'hfff00ff0, 32'hee200a00) || hit(w, 32'hfff00ff0, 32'hee800a00))
      op = OP_RES_S;
    else if (hit(w, 32'hfff00ff0, 32'hee000b10))        op = OP_CORE2FP;
    else if (hit(w, 32'hfff00ff0, 32'hee100b10))        op = OP_FP2CORE;
    else if (hit(w, 32'hffff0ff0, 32'heeb00a40))        op = OP_MOV_S;
    else if (hit(w, 32'hffff0ff0, 32'heeb00b40))        op = OP_MOV_D;
    else if (hit(w, 32'hffff0ff0, 32'heeb00ac0))        op = OP_ABS_S;
    else if (hit(w, 32'hffff0ff0, 32'heeb00bc0))        op = OP_ABS_D;
    else if (hit(w, 32'hffff0ff0, 32'heeb10a40))        op = OP_NEG_S;
    else if (hit(w, 32'hffff0ff0, 32'heeb10b40))        op = OP_NEG_D;
    else if (hit(w, 32'hffff0ff0, 32'heeb40bc0) || hit(w, 32'hffff0ff0, 32'heeb40ac0) ||
             hit(w, 32'hffff0ff0, 32'heeb50bc0) || hit(w, 32'hffff0ff0, 32'heeb50ac0))
      op = OP_CMP;
    else if (hit(w, 32'hffff0ff0, 32'heeb10bc0) || hit(w, 32'hffff0ff0, 32'heeb70ac0) ||
             hit(w, 32'hffff0ff0, 32'heeb80bc0) || hit(w, 32'hffff0ff0, 32'heeb80b40))
      op = OP_RES_D;
    else if (hit(w, 32'hffff0ff0, 32'heeb70bc0) || hit(w, 32'hffff0ff0, 32'heebd0ac0) ||
             hit(w, 32'hffff0ff0, 32'heebc0ac0) || hit(w, 32'hffff0ff0, 32'heebd0bc0) ||
             hit(w, 32'hffff0ff0, 32'heebc0bc0) || hit(w, 32'hffff0ff0, 32'heeb80ac0) ||
             hit(w, 32'hffff0ff0, 32'heeb80a40))
      op = OP_RES_S;
    return op;
  endfunction

  function automatic logic [31:0] imm_single(input logic [7:0] imm);
    logic [31:0] v;
    v = 32'h4000_0000;
    if (imm[7]) v = v | 32'h8000_0000;
    if (imm[6]) v = v ^ 32'h7e00_0000;
    v = v | (32'(imm[5:0]) << 19);
    return v;
  endfunction

  function automatic logic [31:0] imm_double_hi(input logic [7:0] imm);
    logic [31:0] v;
    v = 32'h4000_0000;
    if (imm[7]) v = v | 32'h8000_0000;
    if (imm[6]) v = v ^ 32'h7fc0_0000;
    v = v | (32'(imm[5:0]) << 16);
    return v;
  endfunction

  // Compare outcome to N,Z,C,V nibble.
  function automatic logic [3:0] cmp_nzcv(input logic unord, input logic lt, input logic eq);
    if (unord)   return 4'b0011;
    else if (eq) return 4'b0110;
    else if (lt) return 4'b1000;
    else         return 4'b0010;
  endfunction
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
  import fpx_pkg::*;
(
  input  logic [31:0]      instr,
  output fpx_op_e          op,
  output logic [IDX_W-1:0] f_d,
  output logic [IDX_W-1:0] f_n,
  output logic [IDX_W-1:0] f_m,
  output logic [7:0]       imm8
);
  always_comb begin
    op   = decode_word(instr);
    f_d  = instr[15:12];
    f_n  = instr[19:16];
    f_m  = instr[3:0];
    imm8 = {instr[19:16], instr[3:0]};
  end
endmodule

// File: rtl/fpx_regbank.sv
module fpx_regbank #(
  parameter int unsigned NREG = 16,
  parameter int unsigned HW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [AW-1:0] widx,
  input  logic [HW-1:0] wd_lo,
  input  logic [HW-1:0] wd_hi,
  input  logic [AW-1:0] ra_idx,
  input  logic [AW-1:0] rb_idx,
  input  logic [AW-1:0] rp_idx,
  output logic [2*HW-1:0] ra_data,
  output logic [2*HW-1:0] rb_data,
  output logic [2*HW-1:0] rp_data
);
  logic [NREG-1:0][HW-1:0] mem_lo;
  logic [NREG-1:0][HW-1:0] mem_hi;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_lo[g] <= '0;
        mem_hi[g] <= '0;
      end else begin
        if (we_lo && widx == AW'(g)) mem_lo[g] <= wd_lo;
        if (we_hi && widx == AW'(g)) mem_hi[g] <= wd_hi;
      end
    end
  end

  assign ra_data = {mem_hi[ra_idx], mem_lo[ra_idx]};
  assign rb_data = {mem_hi[rb_idx], mem_lo[rb_idx]};
  assign rp_data = {mem_hi[rp_idx], mem_lo[rp_idx]};

  // R2: a write that leaves the high enable off keeps every high half
  assert_hi_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_hi |=> $stable(mem_hi));
  // R11: no enable, no change anywhere
  assert_idle_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_hi && !we_lo) |=> ($stable(mem_lo) && $stable(mem_hi)));
endmodule

// File: rtl/fpx_datapath.sv
module fpx_datapath
  import fpx_pkg::*;
(
  input  fpx_op_e     op,
  input  logic [63:0] n_val,
  input  logic [63:0] m_val,
  input  logic [7:0]  imm8,
  input  logic [31:0] core_rdata,
  input  logic [63:0] arith_result,
  output logic        we_lo,
  output logic        we_hi,
  output logic        use_n_dest,
  output logic [31:0] wd_lo,
  output logic [31:0] wd_hi
);
  logic [31:0] n_lo, n_hi, m_lo, m_hi;
  assign {n_hi, n_lo} = n_val;
  assign {m_hi, m_lo} = m_val;

  always_comb begin
    we_lo      = 1'b0;
    we_hi      = 1'b0;
    use_n_dest = 1'b0;
    wd_lo      = m_lo;
    wd_hi      = m_hi;
    unique case (op)
      OP_MOV_S:  we_lo = 1'b1;
      OP_MOV_D:  begin we_lo = 1'b1; we_hi = 1'b1; end
      OP_ABS_S:  begin we_lo = 1'b1; wd_lo = {1'b0, m_lo[30:0]}; end
      OP_ABS_D:  begin we_lo = 1'b1; we_hi = 1'b1; wd_hi = {1'b0, m_hi[30:0]}; end
      OP_NEG_S:  begin we_lo = 1'b1; wd_lo = {~m_lo[31], m_lo[30:0]}; end
      OP_NEG_D:  begin we_lo = 1'b1; we_hi = 1'b1; wd_hi = {~m_hi[31], m_hi[30:0]}; end
      OP_XOR:    begin
        we_lo = 1'b1; we_hi = 1'b1;
        wd_lo = m_lo ^ n_lo;
        wd_hi = m_hi ^ n_hi;
      end
      OP_IMM_S:  begin we_lo = 1'b1; wd_lo = imm_single(imm8); end
      OP_IMM_D:  begin we_lo = 1'b1; we_hi = 1'b1; wd_lo = '0; wd_hi = imm_double_hi(imm8); end
      OP_CORE2FP: begin we_lo = 1'b1; use_n_dest = 1'b1; wd_lo = core_rdata; end
      OP_RES_S:  begin we_lo = 1'b1; wd_lo = arith_result[31:0]; end
      OP_RES_D:  begin
        we_lo = 1'b1; we_hi = 1'b1;
        wd_lo = arith_result[31:0];
        wd_hi = arith_result[63:32];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpx_exec_top.sv
module fpx_exec_top
  import fpx_pkg::*;
#(
  parameter int unsigned NREG = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] instr,
  input  logic [31:0] core_rdata,
  input  logic [31:0] core_status,
  input  logic [63:0] arith_result,
  input  logic        cmp_unord,
  input  logic        cmp_lt,
  input  logic        cmp_eq,
  input  logic [3:0]  peek_idx,
  output logic [63:0] peek_data,
  output logic        done,
  output logic        err_unsup,
  output logic        not_fp,
  output logic        core_we,
  output logic [3:0]  core_widx,
  output logic [31:0] core_wdata,
  output logic        status_we,
  output logic [31:0] status_wdata,
  output logic [3:0]  fp_flags
);
  fpx_op_e          op;
  logic [IDX_W-1:0] f_d, f_n, f_m;
  logic [7:0]       imm8;
  logic [63:0]      n_val, m_val;
  logic             dp_we_lo, dp_we_hi, use_n_dest;
  logic [31:0]      wd_lo, wd_hi;

  // named events for the assertions
  logic ev_cmp, ev_fault, ev_ok, bank_we_lo, bank_we_hi;

  fpx_decode u_dec (
    .instr(instr), .op(op), .f_d(f_d), .f_n(f_n), .f_m(f_m), .imm8(imm8)
  );

  fpx_datapath u_dp (
    .op(op), .n_val(n_val), .m_val(m_val), .imm8(imm8),
    .core_rdata(core_rdata), .arith_result(arith_result),
    .we_lo(dp_we_lo), .we_hi(dp_we_hi), .use_n_dest(use_n_dest),
    .wd_lo(wd_lo), .wd_hi(wd_hi)
  );

  assign bank_we_lo = start && dp_we_lo;
  assign bank_we_hi = start && dp_we_hi;

  fpx_regbank #(.NREG(NREG), .HW(32)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we_lo(bank_we_lo), .we_hi(bank_we_hi),
    .widx(use_n_dest ? f_n : f_d),
    .wd_lo(wd_lo), .wd_hi(wd_hi),
    .ra_idx(f_n), .rb_idx(f_m), .rp_idx(peek_idx),
    .ra_data(n_val), .rb_data(m_val), .rp_data(peek_data)
  );

  assign ev_cmp   = start && (op == OP_CMP);
  assign ev_fault = start && (op == OP_BAD || op == OP_NOTFP);
  assign ev_ok    = start && !ev_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_flags     <= 4'h0;
      done         <= 1'b0;
      err_unsup    <= 1'b0;
      not_fp       <= 1'b0;
      core_we      <= 1'b0;
      core_widx    <= '0;
      core_wdata   <= '0;
      status_we    <= 1'b0;
      status_wdata <= '0;
    end else begin
      done      <= ev_ok;
      err_unsup <= start && (op == OP_BAD);
      not_fp    <= start && (op == OP_NOTFP);
      core_we   <= start && (op == OP_FP2CORE);
      status_we <= start && (op == OP_FLAGCOPY);
      if (ev_cmp) fp_flags <= cmp_nzcv(cmp_unord, cmp_lt, cmp_eq);
      if (start && op == OP_FP2CORE) begin
        core_widx  <= f_d;
        core_wdata <= n_val[31:0];
      end
      if (start && op == OP_FLAGCOPY)
        status_wdata <= (core_status & 32'h0fff_ffff) | {fp_flags, 28'h0};
    end
  end

  // R12: at most one completion indication at a time
  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_unsup, not_fp}));
  // R12: an indication only follows a sampled start
  assert_after_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !(done || err_unsup || not_fp));
  // R7: flags only move after a compare
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cmp |=> $stable(fp_flags));
  // R7: only the four legal codes are ever stored
  assert_flags_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fp_flags inside {4'h0, 4'h2, 4'h3, 4'h6, 4'h8});
  // R11: faulting words touch neither the bank nor the core write ports
  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |-> (!bank_we_lo && !bank_we_hi));
  assert_fault_ports_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unsup || not_fp) |-> (!core_we && !status_we));
  // R8/R9: strobes come with done
  assert_strobe_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we || status_we) |-> done);
endmodule

// File: tb/tb_fpx_exec_top.sv
module tb_fpx_exec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] core_rdata = '0;
  logic [31:0] core_status = '0;
  logic [63:0] arith_result = '0;
  logic        cmp_unord = 1'b0, cmp_lt = 1'b0, cmp_eq = 1'b0;
  logic [3:0]  peek_idx = '0;
  logic [63:0] peek_data;
  logic        done, err_unsup, not_fp, core_we, status_we;
  logic [3:0]  core_widx, fp_flags;
  logic [31:0] core_wdata, status_wdata;

  fpx_exec_top dut (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] mlo [16];
  logic [31:0] mhi [16];
  logic [3:0]  mflags;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [31:0] crd, input logic [31:0] cst,
                     input logic [63:0] ar, input logic u, input logic l, input logic e);
    @(negedge clk);
    instr = w; core_rdata = crd; core_status = cst; arith_result = ar;
    cmp_unord = u; cmp_lt = l; cmp_eq = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic peek(input int i, output logic [63:0] v);
    peek_idx = 4'(i);
    #0.5;
    v = peek_data;
  endtask

  task automatic chk_bank(input string tag);
    logic [63:0] v;
    for (int i = 0; i < 16; i++) begin
      peek(i, v);
      chk(tag, v, {mhi[i], mlo[i]});
    end
  endtask

  function automatic logic [31:0] exp_imm_s(input logic [7:0] k);
    return {k[7], ~k[6], {5{k[6]}}, k[5:0], 19'd0};
  endfunction
  function automatic logic [31:0] exp_imm_d(input logic [7:0] k);
    return {k[7], ~k[6], {8{k[6]}}, k[5:0], 16'd0};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [63:0] v;
    for (int i = 0; i < 16; i++) begin mlo[i] = '0; mhi[i] = '0; end
    mflags = 4'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flags", fp_flags, 0);
    chk("R1 strobes", {done, err_unsup, not_fp, core_we, status_we}, 0);
    chk_bank("R1 bank");
    rst_n = 1'b1;
    @(negedge clk);
    chk_bank("R1 bank after release");

    // R10: double writeback fills every register, then single writeback
    for (int d = 0; d < 16; d++) begin
      logic [63:0] ar;
      ar = {32'hA000_0000 + 32'(d) * 32'h0101_0011, 32'h1234_0000 + 32'(d) * 32'h0000_0F07};
      run(32'hee300b00 | (32'(d) << 12) | (32'((d + 1) % 16) << 16) | 32'((d + 2) % 16),
          0, 0, ar, 0, 0, 0);
      mlo[d] = ar[31:0]; mhi[d] = ar[63:32];
      chk("R12 done after write", done, 1);
    end
    chk_bank("R10 double fill");
    run(32'heeb10bc0 | (32'd7 << 12) | 32'd2, 0, 0, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, 0);
    mlo[7] = 32'h0BAD_F00D; mhi[7] = 32'hDEAD_BEEF;
    chk_bank("R10 double convert");
    for (int k = 0; k < 3; k++) begin
      int d;
      d = k * 7 + 1;
      run(32'hee200a00 | (32'(d) << 12), 0, 0, {32'hFFFF_FFFF, 32'h5A5A_0000 | 32'(k)}, 0, 0, 0);
      mlo[d] = 32'h5A5A_0000 | 32'(k);
    end
    run(32'heebd0ac0 | (32'd4 << 12) | 32'd9, 0, 0, {32'h7777_7777, 32'hFFFF_FFF6}, 0, 0, 0);
    mlo[4] = 32'hFFFF_FFF6;
    chk_bank("R2 R10 single writes keep high halves");

    // R3 and R2: copies, abs, neg across register pairs
    for (int d = 0; d < 16; d++) begin
      int m;
      m = (d * 5 + 3) % 16;
      run(32'heeb00ac0 | (32'(d) << 12) | 32'(m), 0, 0, 0, 0, 0, 0);
      mlo[d] = mlo[m] & 32'h7fff_ffff;
      peek(d, v); chk("R3 abs single", v, {mhi[d], mlo[d]});
      run(32'heeb10b40 | (32'(m) << 12) | 32'(d), 0, 0, 0, 0, 0, 0);
      mlo[m] = mlo[d]; mhi[m] = mhi[d] ^ 32'h8000_0000;
      peek(m, v); chk("R3 neg double", v, {mhi[m], mlo[m]});
      run(32'heeb00bc0 | (32'((d + 9) % 16) << 12) | 32'(m), 0, 0, 0, 0, 0, 0);
      mlo[(d + 9) % 16] = mlo[m]; mhi[(d + 9) % 16] = mhi[m] & 32'h7fff_ffff;
      run(32'heeb10a40 | (32'((d + 4) % 16) << 12) | 32'(d), 0, 0, 0, 0, 0, 0);
      mlo[(d + 4) % 16] = mlo[d] ^ 32'h8000_0000;
      run(32'heeb00a40 | (32'((d + 11) % 16) << 12) | 32'((d + 6) % 16), 0, 0, 0, 0, 0, 0);
      mlo[(d + 11) % 16] = mlo[(d + 6) % 16];
      run(32'heeb00b40 | (32'((d + 13) % 16) << 12) | 32'((d + 2) % 16), 0, 0, 0, 0, 0, 0);
      mlo[(d + 13) % 16] = mlo[(d + 2) % 16]; mhi[(d + 13) % 16] = mhi[(d + 2) % 16];
    end
    chk_bank("R3 R2 move sweep");

    // R4: XOR of both halves
    for (int d = 0; d < 16; d++) begin
      int n, m;
      n = (d + 3) % 16; m = (d * 3 + 1) % 16;
      run(32'hf3000110 | (32'(n) << 16) | (32'(d) << 12) | 32'(m), 0, 0, 0, 0, 0, 0);
      mlo[d] = mlo[n] ^ mlo[m]; mhi[d] = mhi[n] ^ mhi[m];
      peek(d, v); chk("R4 xor", v, {mhi[d], mlo[d]});
    end

    // R9: core to bank, bank to core
    for (int n = 0; n < 16; n++) begin
      logic [31:0] c;
      c = 32'hC0DE_0000 | (32'(n) * 32'h0000_1357);
      run(32'hee000b10 | (32'(n) << 16) | (32'((15 - n)) << 12), c, 0, 0, 0, 0, 0);
      mlo[n] = c;
      run(32'hee100b10 | (32'(n) << 16) | (32'((n + 5) % 16) << 12), 0, 0, 0, 0, 0, 0);
      chk("R9 core_we", {core_we, done}, 2'b11);
      chk("R9 core_widx", core_widx, (n + 5) % 16);
      chk("R9 core_wdata", core_wdata, c);
    end
    chk_bank("R9 R2 core transfer");

    // R5 and R6: full immediate sweeps
    for (int k = 0; k < 256; k++) begin
      int d;
      d = k % 16;
      run(32'heeb00a00 | (32'(k >> 4) << 16) | (32'(d) << 12) | 32'(k & 15), 0, 0, 0, 0, 0, 0);
      mlo[d] = exp_imm_s(8'(k));
      peek(d, v); chk("R5 single immediate", v, {mhi[d], mlo[d]});
    end
    for (int k = 0; k < 256; k++) begin
      int d;
      d = (k + 7) % 16;
      run(32'heeb00b00 | (32'(k >> 4) << 16) | (32'(d) << 12) | 32'(k & 15), 0, 0, 0, 0, 0, 0);
      mlo[d] = 32'h0; mhi[d] = exp_imm_d(8'(k));
      peek(d, v); chk("R6 double immediate", v, {mhi[d], mlo[d]});
    end
    chk_bank("R5 R6 bank after sweep");

    // R7 compares and R8 flag copy
    run(32'heeb40bc0 | (32'd1 << 12) | 32'd2, 0, 0, 0, 0, 1, 0);
    chk("R7 less", fp_flags, 4'h8);
    run(32'heeb00a40 | (32'd3 << 12) | 32'd3, 0, 0, 0, 1, 0, 1);
    chk("R7 flags hold on move", fp_flags, 4'h8);
    run(32'heef1fa10, 0, 32'h5ABC_DEF1, 0, 0, 0, 0);
    chk("R8 status", {status_we, status_wdata}, {1'b1, 32'h8ABC_DEF1});
    run(32'heeb40ac0, 0, 0, 0, 1, 1, 1);
    chk("R7 unordered wins", fp_flags, 4'h3);
    run(32'heef1fa10, 0, 32'hF000_0000, 0, 0, 0, 0);
    chk("R8 status unordered", status_wdata, 32'h3000_0000);
    run(32'heeb50bc0 | (32'd9 << 12), 0, 0, 0, 0, 1, 1);
    chk("R7 equal", fp_flags, 4'h6);
    run(32'heeb50ac0, 0, 0, 0, 0, 0, 0);
    chk("R7 greater", fp_flags, 4'h2);
    run(32'heef1fa10, 0, 32'h0123_4567, 0, 0, 0, 0);
    chk("R8 status greater", status_wdata, 32'h2123_4567);
    mflags = 4'h2;

    // R11: faulting words change nothing
    run(32'hee123456, 32'hFFFF_FFFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    chk("R11 unsupported ee", {done, err_unsup, not_fp, core_we, status_we}, 5'b01000);
    run(32'hed900a00 | (32'd5 << 12), 0, 0, 64'h1, 0, 1, 0);
    chk("R11 unsupported ed", {done, err_unsup, not_fp}, 3'b010);
    run(32'h1234_5678, 0, 0, 64'h2, 0, 0, 1);
    chk("R11 not fp", {done, err_unsup, not_fp, core_we, status_we}, 5'b00100);
    run(32'he59fb000, 0, 0, 64'h3, 1, 0, 0);
    chk("R11 not fp 2", {done, err_unsup, not_fp}, 3'b001);
    chk("R11 flags kept", fp_flags, mflags);
    chk_bank("R11 bank kept");

    // R12: outputs drop one cycle later
    @(negedge clk);
    chk("R12 single-cycle pulse", {done, err_unsup, not_fp, core_we, status_we}, 0);
    summary();
  end
endmodule